// File: doc/BRIEF.md
# Per-Processor Power Mode Controller

After every pass of a central task scheduler, this block picks a power mode for each processing element and applies it. There are three modes: full-speed turbo, a half-speed voltage/frequency-scaled mode, and a deep-idle mode in which the element is switched off. The choice depends on two things. The first is whether the element has a task assigned. The second is the fill state of the running task's output buffer. A buffer that has drained to its low mark means the producer is too slow, so the element speeds up. A buffer that has filled to its high mark means the producer is too fast, so the element slows down. This evens out the stage lengths of a streaming pipeline, instead of following raw utilization.

Each mode change is modelled with a switching latency, counted in clock cycles. During that time the element is reported as not ready. Waking from deep idle uses its own, longer count. Entering deep idle and changing between the two speed modes each have their own count too. A request that arrives while a switch is in flight is parked and applied once the switch ends. If several requests arrive, the latest one wins.

Top module: `pmc_top`

## Requirements
- R1: Modes are encoded on two bits: turbo = 0, half speed = 1, deep idle = 2. Element p uses bits [2p+1:2p] of `cur_mode` and `mode_req`.
- R2: When `sched_valid` is high and element p has `pe_busy[p]` low, element p is requested into deep idle.
- R3: When `sched_valid` is high and `pe_busy[p]` and `thr_low[p]` are high, turbo is requested. This takes priority over `thr_high[p]`.
- R4: When `sched_valid` is high, `pe_busy[p]` and `thr_high[p]` are high and `thr_low[p]` is low, half speed is requested.
- R5: A busy element with neither threshold flag set keeps its mode. Without `sched_valid`, no element changes mode.
- R6: Once a request for a different mode is accepted, `pe_ready[p]` is low for exactly LAT_SLEEP cycles when the target is deep idle. It is low for exactly LAT_WAKE cycles when leaving deep idle, and for exactly LAT_DVFS cycles between turbo and half speed. During the switch, `mode_req` shows the target and `cur_mode` shows the old mode. `cur_mode` takes the new value as ready returns.
- R7: A request made while a switch is in flight does not alter the switch in progress. The latest such request is started right after the switch completes. A request equal to the present mode starts no switch.
- R8: After reset every element is in turbo and ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sched_valid | input | 1 | One-cycle strobe at the end of a scheduling pass |
| pe_busy | input | NUM_PE | Element has a task assigned |
| thr_low | input | NUM_PE | Running task's output buffer reached its low mark |
| thr_high | input | NUM_PE | Running task's output buffer reached its high mark |
| mode_req | output | 2*NUM_PE | Mode being applied (target during a switch) |
| cur_mode | output | 2*NUM_PE | Mode in effect |
| pe_ready | output | NUM_PE | Element not switching |

## Verification
Directed passes apply each decision pattern in isolation: a free element, a low mark, a high mark, both marks, and neither mark. These passes confirm the threshold priority and the keep case. Each transition kind is timed on its own, so a swapped or off-by-one latency shows as a wrong not-ready count. A request injected during a wake-up separates parked handling from in-flight overwrite. A long run of random strobes and flags is then compared every clock against a behavioural model, which exposes interactions between parked requests and completing switches.

// File: rtl/pmc_pkg.sv
// Shared types for the power mode controller.
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_TURBO = 2'd0,
        PM_HALF  = 2'd1,
        PM_IDLE  = 2'd2
    } pm_mode_e;
endpackage

// File: rtl/pmc_decide.sv
// Per-element mode decision.
// Maps the busy flag and buffer threshold flags of one element to an
// optional mode request. Purely combinational; assumes the flags are
// valid whenever the caller qualifies the result with its strobe.
module pmc_decide
    import pmc_pkg::*;
(
    input  logic     busy,
    input  logic     low_mark,
    input  logic     high_mark,
    output logic     want_vld,
    output pm_mode_e want_mode
);
    // Priority: free element, then low mark, then high mark, else keep.
    always_comb begin
        want_vld  = 1'b1;
        want_mode = PM_TURBO;
        if (!busy) begin
            want_mode = PM_IDLE;
        end else if (low_mark) begin
            want_mode = PM_TURBO;
        end else if (high_mark) begin
            want_mode = PM_HALF;
        end else begin
            want_vld  = 1'b0;
        end
    end
endmodule

// File: rtl/pmc_pe_fsm.sv
// Per-element switch sequencer.
// Holds the mode in effect, runs a switch with a latency that depends
// on the transition kind, and parks a request that arrives during a
// switch. Assumes every latency parameter is at least 1.
module pmc_pe_fsm
    import pmc_pkg::*;
#(
    parameter int LAT_DVFS  = 2,
    parameter int LAT_WAKE  = 6,
    parameter int LAT_SLEEP = 3
)(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_vld,
    input  pm_mode_e req_mode,
    output logic     ready,
    output pm_mode_e cur_mode,
    output pm_mode_e tgt_mode
);
    localparam int LAT_A   = (LAT_DVFS > LAT_WAKE) ? LAT_DVFS : LAT_WAKE;
    localparam int LAT_MAX = (LAT_A > LAT_SLEEP) ? LAT_A : LAT_SLEEP;
    localparam int CW      = $clog2(LAT_MAX + 1);

    logic          sw_q;
    logic [CW-1:0] cnt_q;
    pm_mode_e      cur_q, tgt_q, pend_mode_q;
    logic          pend_vld_q;
    logic          nxt_vld;
    pm_mode_e      nxt_mode;

    // Cycle count of a transition from one mode to another.
    function automatic logic [CW-1:0] lat_of(pm_mode_e from_m, pm_mode_e to_m);
        if (to_m == PM_IDLE)        return CW'(LAT_SLEEP);
        else if (from_m == PM_IDLE) return CW'(LAT_WAKE);
        else                        return CW'(LAT_DVFS);
    endfunction

    // A fresh request overrides a parked one.
    always_comb begin
        nxt_vld  = req_vld | pend_vld_q;
        nxt_mode = req_vld ? req_mode : pend_mode_q;
    end

    // Switch sequencing and request parking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q        <= 1'b0;
            cnt_q       <= '0;
            cur_q       <= PM_TURBO;
            tgt_q       <= PM_TURBO;
            pend_vld_q  <= 1'b0;
            pend_mode_q <= PM_TURBO;
        end else if (sw_q) begin
            if (cnt_q == CW'(1)) begin
                cur_q <= tgt_q;
                sw_q  <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
            if (req_vld) begin
                pend_vld_q  <= 1'b1;
                pend_mode_q <= req_mode;
            end
        end else begin
            pend_vld_q <= 1'b0;
            if (nxt_vld && (nxt_mode != cur_q)) begin
                sw_q  <= 1'b1;
                tgt_q <= nxt_mode;
                cnt_q <= lat_of(cur_q, nxt_mode);
            end
        end
    end

    assign ready    = !sw_q;
    assign cur_mode = cur_q;
    assign tgt_mode = tgt_q;

    AST_MODE_CHANGES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> !sw_q); // R6
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q |-> (cnt_q != '0) && (cnt_q <= CW'(LAT_MAX))); // R6
    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_q && $past(sw_q)) |-> $stable(tgt_q)); // R7
    AST_SETTLED_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_q |-> (tgt_q == cur_q)); // R7
endmodule

// File: rtl/pmc_top.sv
// Power mode controller for NUM_PE processing elements.
// On each scheduling strobe, derives a mode per element from its busy
// and buffer threshold flags and applies it through a per-element
// sequencer. Assumes sched_valid is a single-cycle strobe.
module pmc_top
    import pmc_pkg::*;
#(
    parameter int NUM_PE    = 4,
    parameter int LAT_DVFS  = 2,
    parameter int LAT_WAKE  = 6,
    parameter int LAT_SLEEP = 3
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sched_valid,
    input  logic [NUM_PE-1:0]   pe_busy,
    input  logic [NUM_PE-1:0]   thr_low,
    input  logic [NUM_PE-1:0]   thr_high,
    output logic [2*NUM_PE-1:0] mode_req,
    output logic [2*NUM_PE-1:0] cur_mode,
    output logic [NUM_PE-1:0]   pe_ready
);
    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
        logic     want_vld;
        pm_mode_e want_mode;
        pm_mode_e cur_m, tgt_m;

        pmc_decide u_dec (
            .busy      (pe_busy[p]),
            .low_mark  (thr_low[p]),
            .high_mark (thr_high[p]),
            .want_vld  (want_vld),
            .want_mode (want_mode)
        );

        pmc_pe_fsm #(
            .LAT_DVFS  (LAT_DVFS),
            .LAT_WAKE  (LAT_WAKE),
            .LAT_SLEEP (LAT_SLEEP)
        ) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_vld  (sched_valid & want_vld),
            .req_mode (want_mode),
            .ready    (pe_ready[p]),
            .cur_mode (cur_m),
            .tgt_mode (tgt_m)
        );

        assign cur_mode[2*p +: 2] = cur_m;
        assign mode_req[2*p +: 2] = tgt_m;

        AST_FREE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (sched_valid && !pe_busy[p] && pe_ready[p] && cur_mode[2*p +: 2] != 2'd2)
            |=> (!pe_ready[p] && mode_req[2*p +: 2] == 2'd2)); // R2
        AST_LOW_GOES_TURBO: assert property (@(posedge clk) disable iff (!rst_n)
            (sched_valid && pe_busy[p] && thr_low[p] && pe_ready[p] && cur_mode[2*p +: 2] != 2'd0)
            |=> (!pe_ready[p] && mode_req[2*p +: 2] == 2'd0)); // R3
        AST_HIGH_GOES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
            (sched_valid && pe_busy[p] && !thr_low[p] && thr_high[p] && pe_ready[p]
             && cur_mode[2*p +: 2] != 2'd1)
            |=> (!pe_ready[p] && mode_req[2*p +: 2] == 2'd1)); // R4
        AST_QUIET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (!sched_valid && pe_ready[p] && $past(pe_ready[p]) && $past(!sched_valid))
            |=> pe_ready[p]); // R5
    end
endmodule

// File: tb/pmc_top_tb.sv
module pmc_top_tb;
    localparam int N  = 4;
    localparam int LD = 2;
    localparam int LW = 6;
    localparam int LS = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sched_valid = 1'b0;
    logic [N-1:0]   pe_busy = '1;
    logic [N-1:0]   thr_low = '0;
    logic [N-1:0]   thr_high = '0;
    logic [2*N-1:0] mode_req, cur_mode;
    logic [N-1:0]   pe_ready;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    pmc_top #(.NUM_PE(N), .LAT_DVFS(LD), .LAT_WAKE(LW), .LAT_SLEEP(LS)) u_dut (
        .clk(clk), .rst_n(rst_n), .sched_valid(sched_valid),
        .pe_busy(pe_busy), .thr_low(thr_low), .thr_high(thr_high),
        .mode_req(mode_req), .cur_mode(cur_mode), .pe_ready(pe_ready)
    );

    always #10 clk = ~clk;

    // Behavioural reference: per-element mode, target, countdown, parked request.
    int m_cur[N], m_tgt[N], m_left[N], m_park[N];

    function automatic int cost(int a, int b);
        if (b == 2) return LS;
        if (a == 2) return LW;
        return LD;
    endfunction

    always @(posedge clk) begin
        for (int p = 0; p < N; p++) begin
            int want;
            want = -1;
            if (sched_valid) begin
                if (!pe_busy[p]) want = 2;
                else if (thr_low[p]) want = 0;
                else if (thr_high[p]) want = 1;
            end
            if (!rst_n) begin
                m_cur[p] = 0; m_tgt[p] = 0; m_left[p] = 0; m_park[p] = -1;
            end else if (m_left[p] > 0) begin
                m_left[p]--;
                if (m_left[p] == 0) m_cur[p] = m_tgt[p];
                if (want >= 0) m_park[p] = want;
            end else begin
                if (want < 0) want = m_park[p];
                m_park[p] = -1;
                if (want >= 0 && want != m_cur[p]) begin
                    m_tgt[p] = want;
                    m_left[p] = cost(m_cur[p], want);
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Every-clock comparison against the reference.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int p = 0; p < N; p++) begin
                chk(int'(cur_mode[2*p +: 2]) == m_cur[p], "R1 cur_mode vs model",
                    int'(cur_mode[2*p +: 2]), m_cur[p]);
                chk(int'(mode_req[2*p +: 2]) == m_tgt[p], "R6 mode_req vs model",
                    int'(mode_req[2*p +: 2]), m_tgt[p]);
                chk(int'(pe_ready[p]) == int'(m_left[p] == 0), "R6 pe_ready vs model",
                    int'(pe_ready[p]), int'(m_left[p] == 0));
            end
        end
    end

    task automatic pass(logic [N-1:0] b, logic [N-1:0] lo, logic [N-1:0] hi);
        @(negedge clk); #1;
        sched_valid = 1'b1; pe_busy = b; thr_low = lo; thr_high = hi;
        @(negedge clk); #1;
        sched_valid = 1'b0;
    endtask

    task automatic time_switch(int p, int exp, string tag);
        int n;
        n = 0;
        while (!pe_ready[p] && n < 50) begin
            n++;
            @(negedge clk); #1;
        end
        chk(n == exp, tag, n, exp);
    endtask

    task automatic idle_cycles(int k);
        repeat (k) @(negedge clk);
        #1;
    endtask

    function automatic int md(int p);
        return int'(cur_mode[2*p +: 2]);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        for (int p = 0; p < N; p++) begin
            chk(md(p) == 0, "R8 reset mode turbo", md(p), 0);
            chk(pe_ready[p] == 1'b1, "R8 reset ready", int'(pe_ready[p]), 1);
        end

        // R4 high mark -> half, DVFS latency
        pass(4'b1111, 4'b0000, 4'b0010);
        chk(int'(mode_req[3:2]) == 1, "R4 target half", int'(mode_req[3:2]), 1);
        chk(md(1) == 0, "R6 old mode shown during switch", md(1), 0);
        time_switch(1, LD, "R6 dvfs latency");
        chk(md(1) == 1, "R4 element now half", md(1), 1);

        // R2 free element -> idle, sleep latency
        pass(4'b1110, 4'b0000, 4'b0000);
        time_switch(0, LS, "R6 sleep latency");
        chk(md(0) == 2, "R2 element idle", md(0), 2);

        // R5 neither mark keeps mode
        pass(4'b1111, 4'b0000, 4'b0000);
        chk(pe_ready[1] == 1'b1 && md(1) == 1, "R5 keep half", md(1), 1);
        chk(pe_ready[0] == 1'b1 && md(0) == 2, "R5 keep idle", md(0), 2);

        // R3 wake via low mark, with a request parked during the switch (R7)
        pass(4'b1111, 4'b0001, 4'b0000);
        pass(4'b1111, 4'b0000, 4'b0001);
        chk(int'(mode_req[1:0]) == 0, "R7 in-flight target kept", int'(mode_req[1:0]), 0);
        idle_cycles(LW + LD + 4);
        chk(md(0) == 1, "R7 parked request applied", md(0), 1);

        // R3 low wins over high
        pass(4'b1111, 4'b0010, 4'b0010);
        time_switch(1, LD, "R3 low beats high latency");
        chk(md(1) == 0, "R3 low beats high", md(1), 0);

        // R7 request equal to current mode starts nothing
        pass(4'b1111, 4'b0010, 4'b0000);
        chk(pe_ready[1] == 1'b1, "R7 same mode no switch", int'(pe_ready[1]), 1);

        // Random traffic compared to the model every clock
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            sched_valid = ($urandom % 4) == 0;
            pe_busy  = N'($urandom);
            thr_low  = N'($urandom) & N'($urandom);
            thr_high = N'($urandom);
        end
        sched_valid = 1'b0;
        idle_cycles(20);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule